// File: doc/BRIEF.md
# GPIO external interrupt controller

This block is the edge and level detector for one bank of external interrupt lines, up to 32 of them. Each line has a pad input and a function-select input. The function-select input tells the block that the pin's multiplexer currently routes the pad to the interrupt function. A line whose function-select input is low never raises an event. Pad values pass through a synchronizer. A sample stage then captures them, either on every clock or once every 2^s clocks when the debounce prescaler is set to s.

Each line has its own 4-bit trigger-mode field. The supported modes are rising edge, falling edge, both edges, high level and low level. Detected events set pending bits in a status word, and software clears a pending bit by writing 1 to it. The pending bits that are also enabled are ORed into one registered interrupt output. Software reaches the block through a small word-addressed register window: four trigger-configuration words, an enable word, the status word and a debounce word.

The logic runs as a fixed pipeline and has no control state machine. The stages are the synchronizer (two flops by default), the sample stage (current sample, previous sample and a "fresh" flag), the per-line detector, the status register and the interrupt register.

Top module: `eint_bank_ctrl`

## Requirements
- R1: After reset, every trigger field, the enable word, the status word and the debounce word read 0, and `irq_out` is 0.
- R2: Trigger code 0 (rising) sets the line's status bit on a 0-to-1 change between two consecutive samples. The field for line i sits in the word at offset 4*(i/8), bits 4*(i%8)+3 down to 4*(i%8). With the prescaler at 0, a pad change made before rising edge k first shows in status after edge k+3.
- R3: Trigger code 1 (falling) sets status only on a 1-to-0 change between samples. A 0-to-1 change has no effect.
- R4: Trigger code 4 (both) sets status on either sample change.
- R5: Trigger code 2 (high level) and code 3 (low level) set status on every cycle the active level is sampled. A write-1 clear has no lasting effect while that level remains.
- R6: Trigger codes 5 to 15 never set status.
- R7: The status word at offset 0x14 is write-1-to-clear: writing 1 to a bit clears it, and writing 0 leaves it unchanged. Status bits are set only by detected events.
- R8: When an event and a write-1 clear hit the same bit in the same cycle, the bit ends set.
- R9: The enable word at offset 0x10 masks a line's contribution to `irq_out` but does not stop its status bit from latching. `irq_out` is the registered OR of (status AND enable) and follows status by one clock.
- R10: A line whose `irq_func_sel` bit is 0 never sets status, whatever its pad does.
- R11: The debounce word at offset 0x18, bits 2:0 = s, takes one sample every 2^s clocks. A sample is taken in the cycle where the low s bits of a free-running 7-bit counter (reset 0, one step per clock) are all ones. With s = 0, a sample is taken every clock.
- R12: The configuration, enable and debounce words read back as written (debounce bits 31:3 read 0). Offsets outside the seven defined words read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | 5 | Byte offset within the bank window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pad_in | input | NUM_LINES | Raw pad levels |
| irq_func_sel | input | NUM_LINES | 1 when the pin's function selector picks the interrupt function |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions check, on every cycle, that edge events appear only in the cycle after a fresh sample, that undefined codes and deselected lines never raise events, that a write-1 clear without an event empties the bit, and that an event always beats a clear. They also check that `irq_out` rises only after an enabled bit was pending, and that a zero prescaler samples every clock. Only the bench scenarios show the exact latency from pad to status and to `irq_out`, the level persistence after a clear, the sample grid chosen by the debounce word, and the readback of the register window. The bench compares these against its cycle model.

// File: rtl/eint_pkg.sv
package eint_pkg;
    localparam int ADDR_W         = 5;
    localparam int DATA_W         = 32;
    localparam int MODE_W         = 4;
    localparam int LINES_PER_WORD = DATA_W / MODE_W;

    localparam logic [ADDR_W-1:0] OFS_ENABLE   = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_DEBOUNCE = 5'h18;

    typedef enum logic [MODE_W-1:0] {
        TRIG_RISE = 4'd0,
        TRIG_FALL = 4'd1,
        TRIG_HIGH = 4'd2,
        TRIG_LOW  = 4'd3,
        TRIG_BOTH = 4'd4
    } trig_e;
endpackage

// File: rtl/eint_prescaler.sv
module eint_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] ps_sel,
    output logic            tick
);
    localparam int CNT_W = (1 << PS_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    // free-running counter; a tick when the low ps_sel bits are all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign mask = ~({CNT_W{1'b1}} << ps_sel);
    assign tick = ((cnt_q & mask) == mask);
endmodule

// File: rtl/eint_sampler.sv
module eint_sampler #(
    parameter int NUM_LINES   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] pad_in,
    input  logic                 tick,
    output logic [NUM_LINES-1:0] cur,
    output logic [NUM_LINES-1:0] prev,
    output logic                 fresh
);
    logic [NUM_LINES-1:0] sync_q [SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
        end else begin
            sync_q[0] <= pad_in;
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur   <= '0;
            prev  <= '0;
            fresh <= 1'b0;
        end else begin
            fresh <= tick;
            if (tick) begin
                prev <= cur;
                cur  <= sync_q[SYNC_STAGES-1];
            end
        end
    end

    // R11: the sample only moves in a cycle flagged fresh
    assert_cur_moves_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !fresh |-> $stable(cur))
        else $error("sample changed without a prescaler tick");
endmodule

// File: rtl/eint_detect.sv
module eint_detect
    import eint_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES*MODE_W-1:0] mode_flat,
    input  logic [NUM_LINES-1:0]        cur,
    input  logic [NUM_LINES-1:0]        prev,
    input  logic                        fresh,
    input  logic [NUM_LINES-1:0]        func_sel,
    output logic [NUM_LINES-1:0]        evt
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [MODE_W-1:0] mode_i;
        logic              raw;
        logic              is_edge;

        assign mode_i  = mode_flat[i*MODE_W +: MODE_W];
        assign is_edge = (mode_i == TRIG_RISE) || (mode_i == TRIG_FALL) || (mode_i == TRIG_BOTH);

        always_comb begin
            case (mode_i)
                TRIG_RISE: raw = fresh & cur[i] & ~prev[i];
                TRIG_FALL: raw = fresh & ~cur[i] & prev[i];
                TRIG_BOTH: raw = fresh & (cur[i] ^ prev[i]);
                TRIG_HIGH: raw = cur[i];
                TRIG_LOW:  raw = ~cur[i];
                default:   raw = 1'b0;
            endcase
        end

        assign evt[i] = func_sel[i] & raw;

        // R2: edge modes fire only right after a new sample
        assert_edge_waits_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!fresh && is_edge) |-> !evt[i])
            else $error("edge event without fresh sample");

        // R6: undefined codes stay silent
        assert_bad_code_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i > 4'd4) |-> !evt[i])
            else $error("event from undefined trigger code");
    end

    // R10: a deselected line never raises an event
    assert_func_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & ~func_sel) == '0))
        else $error("event on line without interrupt function");
endmodule

// File: rtl/eint_regs.sv
module eint_regs
    import eint_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PS_W      = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic [NUM_LINES-1:0]        evt,
    output logic [NUM_LINES*MODE_W-1:0] mode_flat,
    output logic [NUM_LINES-1:0]        en_q,
    output logic [NUM_LINES-1:0]        stat_q,
    output logic [PS_W-1:0]             ps_sel
);
    localparam int CFG_WORDS = (NUM_LINES + LINES_PER_WORD - 1) / LINES_PER_WORD;
    localparam int CFG_BITS  = CFG_WORDS * DATA_W;

    logic [CFG_BITS-1:0]  cfg_q;
    logic [NUM_LINES-1:0] clr;
    logic                 wr_stat;

    assign mode_flat = cfg_q[NUM_LINES*MODE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            en_q   <= '0;
            ps_sel <= '0;
        end else if (reg_wr) begin
            for (int w = 0; w < CFG_WORDS; w++)
                if (reg_addr == ADDR_W'(w * 4)) cfg_q[w*DATA_W +: DATA_W] <= reg_wdata;
            if (reg_addr == OFS_ENABLE)   en_q   <= reg_wdata[NUM_LINES-1:0];
            if (reg_addr == OFS_DEBOUNCE) ps_sel <= reg_wdata[PS_W-1:0];
        end
    end

    // write-1-to-clear; a same-cycle event takes priority
    assign wr_stat = reg_wr && (reg_addr == OFS_STATUS);
    assign clr     = wr_stat ? reg_wdata[NUM_LINES-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | evt;
    end

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < CFG_WORDS; w++)
            if (reg_addr == ADDR_W'(w * 4)) reg_rdata = cfg_q[w*DATA_W +: DATA_W];
        if (reg_addr == OFS_ENABLE)   reg_rdata[NUM_LINES-1:0] = en_q;
        if (reg_addr == OFS_STATUS)   reg_rdata[NUM_LINES-1:0] = stat_q;
        if (reg_addr == OFS_DEBOUNCE) reg_rdata[PS_W-1:0]      = ps_sel;
    end

    // R7: a cleared bit with no event is empty afterwards
    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((stat_q & $past(clr & ~evt)) == '0))
        else $error("write-1 clear did not take effect");

    // R7: status bits appear only from events
    assert_set_needs_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt)) == '0))
        else $error("status bit set without event");

    // R8: an event always lands, even against a clear
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)))
        else $error("event lost");
endmodule

// File: rtl/eint_bank_ctrl.sv
module eint_bank_ctrl
    import eint_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int PS_W        = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [4:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    input  logic [NUM_LINES-1:0] irq_func_sel,
    output logic                 irq_out
);
    logic [NUM_LINES*MODE_W-1:0] mode_flat;
    logic [NUM_LINES-1:0]        en_q;
    logic [NUM_LINES-1:0]        stat_q;
    logic [NUM_LINES-1:0]        cur;
    logic [NUM_LINES-1:0]        prev;
    logic [NUM_LINES-1:0]        evt;
    logic [PS_W-1:0]             ps_sel;
    logic                        tick;
    logic                        fresh;

    eint_prescaler #(.PS_W(PS_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .ps_sel(ps_sel), .tick(tick)
    );

    eint_sampler #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .tick(tick),
        .cur(cur), .prev(prev), .fresh(fresh)
    );

    eint_detect #(.NUM_LINES(NUM_LINES)) u_det (
        .clk(clk), .rst_n(rst_n), .mode_flat(mode_flat), .cur(cur), .prev(prev),
        .fresh(fresh), .func_sel(irq_func_sel), .evt(evt)
    );

    eint_regs #(.NUM_LINES(NUM_LINES), .PS_W(PS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt),
        .mode_flat(mode_flat), .en_q(en_q), .stat_q(stat_q), .ps_sel(ps_sel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |(stat_q & en_q);
    end

    // R9: the request rises only after an enabled bit was pending
    assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past((stat_q & en_q) != '0))
        else $error("irq without enabled pending bit");

    // R11: prescaler setting 0 gives a fresh sample every clock
    assert_full_rate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_sel == '0) |=> fresh)
        else $error("missing sample at full rate");
endmodule

// File: tb/eint_bank_ctrl_bench.sv
module eint_bank_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [31:0] pad_in;
    logic [31:0] func_sel;
    logic        irq_out;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    bit    cmp_on   = 0;
    string cur_req  = "R1";

    always #4 clk = ~clk;

    eint_bank_ctrl u_eint_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .irq_func_sel(func_sel), .irq_out(irq_out)
    );

    // ---------------- behavioural reference ----------------
    bit [3:0]  m_mode [32];
    bit [31:0] m_en, m_stat, m_cur, m_prev;
    bit        m_fresh, m_irq;
    int        m_sel, m_cnt;
    bit [31:0] m_pipe [$];

    function automatic bit [31:0] m_read(input bit [4:0] a);
        bit [31:0] r = 0;
        if (a < 5'h10 && a[1:0] == 2'b00) begin
            for (int k = 0; k < 8; k++) r[4*k +: 4] = m_mode[(a >> 2) * 8 + k];
        end else if (a == 5'h10) r = m_en;
        else if (a == 5'h14) r = m_stat;
        else if (a == 5'h18) r = 32'(m_sel);
        return r;
    endfunction

    always @(posedge clk) begin : model
        bit [31:0] ev, clr, nstat, s2;
        bit        nirq, tk;
        int        per;
        if (!rst_n) begin
            foreach (m_mode[i]) m_mode[i] = 0;
            m_en = 0; m_stat = 0; m_cur = 0; m_prev = 0;
            m_fresh = 0; m_irq = 0; m_sel = 0; m_cnt = 0;
            m_pipe = '{32'h0, 32'h0};
        end else begin
            ev = 0;
            for (int i = 0; i < 32; i++) begin
                case (m_mode[i])
                    4'd0: ev[i] = m_fresh && m_cur[i] && !m_prev[i];
                    4'd1: ev[i] = m_fresh && !m_cur[i] && m_prev[i];
                    4'd2: ev[i] = m_cur[i];
                    4'd3: ev[i] = !m_cur[i];
                    4'd4: ev[i] = m_fresh && (m_cur[i] != m_prev[i]);
                    default: ev[i] = 0;
                endcase
                ev[i] = ev[i] && func_sel[i];
            end
            nirq  = (m_stat & m_en) != 0;
            clr   = (reg_wr && reg_addr == 5'h14) ? reg_wdata : 32'h0;
            nstat = (m_stat & ~clr) | ev;
            per   = 1 << m_sel;
            tk    = (m_cnt % per) == per - 1;
            s2    = m_pipe[1];
            if (reg_wr) begin
                if (reg_addr < 5'h10 && reg_addr[1:0] == 2'b00)
                    for (int k = 0; k < 8; k++) m_mode[(reg_addr >> 2) * 8 + k] = reg_wdata[4*k +: 4];
                else if (reg_addr == 5'h10) m_en = reg_wdata;
                else if (reg_addr == 5'h18) m_sel = int'(reg_wdata[2:0]);
            end
            m_fresh = tk;
            if (tk) begin
                m_prev = m_cur;
                m_cur  = s2;
            end
            void'(m_pipe.pop_back());
            m_pipe.push_front(pad_in);
            m_cnt  = (m_cnt + 1) % 128;
            m_stat = nstat;
            m_irq  = nirq;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && cmp_on) begin
            chk(cur_req, "rdata vs model", reg_rdata, m_read(reg_addr));
            chk(cur_req, "irq vs model", {31'b0, irq_out}, {31'b0, m_irq});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 60000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit [4:0] a, input bit [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 5'h14;
    endtask

    task automatic chk_read(input string req, input bit [4:0] a, input bit [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #2;
        chk(req, "register readback", reg_rdata, exp);
        reg_addr = 5'h14;
    endtask

    task automatic chk_bit(input string req, input int b, input bit exp);
        #2;
        chk(req, "status bit", {31'b0, reg_rdata[b]}, {31'b0, exp});
    endtask

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 5'h14; reg_wdata = '0;
        pad_in = '0; func_sel = '0;
        settle(4);
        rst_n = 1'b1; cmp_on = 1;

        cur_req = "R1";
        #2;
        chk("R1", "status after reset", reg_rdata, 32'h0);
        chk("R1", "irq after reset", {31'b0, irq_out}, 32'h0);
        chk_read("R1", 5'h00, 32'h0);
        chk_read("R1", 5'h10, 32'h0);
        chk_read("R1", 5'h18, 32'h0);

        cur_req = "R12";
        wr(5'h00, 32'h0074_3210);   // l0 rise, l1 fall, l2 high, l3 low, l4 both, l5 code 7
        wr(5'h04, 32'h0000_0004);   // l8 both
        wr(5'h10, 32'hFFFF_FFFF);
        chk_read("R12", 5'h00, 32'h0074_3210);
        chk_read("R12", 5'h04, 32'h0000_0004);

        cur_req = "R10";
        @(negedge clk); pad_in = 32'h0000_0115;
        settle(8);
        @(negedge clk); pad_in = 32'h0;
        settle(8);
        chk("R10", "status with function deselected", reg_rdata, 32'h0);

        func_sel = 32'hFFFF_FFFF;
        wr(5'h10, 32'h1);
        wr(5'h14, 32'hFFFF_FFFF);
        settle(3);

        cur_req = "R2";
        @(negedge clk); pad_in[0] = 1'b1;
        settle(3);
        chk_bit("R2", 0, 1'b0);
        @(negedge clk);
        chk_bit("R2", 0, 1'b1);
        chk("R9", "irq one clock after status", {31'b0, irq_out}, 32'h0);
        @(negedge clk); #2;
        chk("R9", "irq after status", {31'b0, irq_out}, 32'h1);

        cur_req = "R3";
        @(negedge clk); pad_in[1] = 1'b1;
        settle(6);
        chk_bit("R3", 1, 1'b0);
        @(negedge clk); pad_in[1] = 1'b0;
        settle(6);
        chk_bit("R3", 1, 1'b1);

        cur_req = "R4";
        @(negedge clk); pad_in[4] = 1'b1;
        settle(6);
        chk_bit("R4", 4, 1'b1);
        wr(5'h14, 32'h10);
        chk_bit("R7", 4, 1'b0);
        @(negedge clk); pad_in[4] = 1'b0;
        settle(6);
        chk_bit("R4", 4, 1'b1);

        cur_req = "R8";
        @(negedge clk); pad_in[4] = 1'b1;
        settle(3);
        reg_wr = 1'b1; reg_addr = 5'h14; reg_wdata = 32'h10;
        @(negedge clk);
        reg_wr = 1'b0;
        chk_bit("R8", 4, 1'b1);
        cur_req = "R7";
        wr(5'h14, 32'h10);
        chk_bit("R7", 4, 1'b0);
        wr(5'h14, 32'h0);
        chk_bit("R7", 0, 1'b1);

        cur_req = "R5";
        @(negedge clk); pad_in[2] = 1'b1;
        settle(6);
        wr(5'h14, 32'h4);
        chk_bit("R5", 2, 1'b1);
        @(negedge clk); pad_in[2] = 1'b0;
        settle(6);
        wr(5'h14, 32'h4);
        chk_bit("R5", 2, 1'b0);
        @(negedge clk); pad_in[3] = 1'b1;
        settle(6);
        wr(5'h14, 32'h8);
        chk_bit("R5", 3, 1'b0);
        @(negedge clk); pad_in[3] = 1'b0;
        settle(6);
        chk_bit("R5", 3, 1'b1);

        cur_req = "R6";
        @(negedge clk); pad_in[5] = 1'b1;
        settle(6);
        @(negedge clk); pad_in[5] = 1'b0;
        settle(6);
        chk_bit("R6", 5, 1'b0);

        cur_req = "R9";
        wr(5'h10, 32'h0);
        settle(2); #2;
        chk("R9", "irq masked", {31'b0, irq_out}, 32'h0);
        chk("R9", "status kept while masked", {31'b0, reg_rdata[1]}, 32'h1);
        wr(5'h10, 32'h2);
        settle(2); #2;
        chk("R9", "irq unmasked", {31'b0, irq_out}, 32'h1);

        cur_req = "R11";
        @(negedge clk); pad_in[0] = 1'b0;
        wr(5'h18, 32'h3);
        chk_read("R12", 5'h18, 32'h3);
        settle(20);
        wr(5'h14, 32'hFFFF_FFF7);
        for (int p = 0; p < 12; p++) begin
            @(negedge clk); pad_in[0] = 1'b1; pad_in[4] = ~pad_in[4];
            @(negedge clk); pad_in[0] = 1'b0;
            settle(p % 5);
        end
        wr(5'h14, 32'h1);
        @(negedge clk); pad_in[0] = 1'b1;
        settle(24);
        chk_bit("R11", 0, 1'b1);
        wr(5'h18, 32'h0);

        cur_req = "R12";
        wr(5'h1C, 32'hFFFF_FFFF);
        chk_read("R12", 5'h1C, 32'h0);
        chk_read("R12", 5'h10, 32'h2);
        chk_read("R12", 5'h00, 32'h0074_3210);

        cur_req = "R9 mixed traffic";
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            reg_wr = 1'b0; reg_addr = 5'h14;
            if ($urandom_range(0, 3) == 0) pad_in = pad_in ^ (32'h1 << $urandom_range(0, 31));
            if ($urandom_range(0, 63) == 0) func_sel = $urandom;
            if ($urandom_range(0, 15) == 0) begin
                reg_wr = 1'b1;
                reg_addr = 5'(4 * $urandom_range(0, 7));
                reg_wdata = $urandom;
                if (reg_addr == 5'h18) reg_wdata = 32'($urandom_range(0, 2));
            end
        end
        @(negedge clk); reg_wr = 1'b0; reg_addr = 5'h14;
        settle(4);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule